// File: doc/BRIEF.md
# SAR Converter Conversion and Readout Sequencer

This block drives a single 16-bit successive-approximation converter whose convert strobe also acts as its chip select, with no busy flag available. On an accepted start request the sequencer produces a fresh rising edge on the strobe and holds the strobe high for a programmable worst-case conversion time. While the strobe is high it keeps the serial clock low. It then drops the strobe, which puts the most significant bit on the data line, and issues sixteen serial clock pulses. It samples the data line on every falling clock edge and assembles the word most significant bit first.

After the sixteenth falling edge the strobe returns high. The assembled word is presented for exactly one cycle together with a valid pulse, and the sequencer goes back to idle. The serial clock half-period, the conversion time and the minimum spacing between accepted starts are all counted in system clock cycles and are taken from input ports.

The state machine has six states. IDLE holds the strobe high and accepts a start once the cycle-time counter has run out (transition "accept"). PREP lowers the strobe for one cycle, then goes to CONV ("arm"). CONV holds the strobe high until the conversion timer expires, then goes to RD_LO ("release"). RD_LO holds the clock low for a half period, then goes to RD_HI ("rise"). RD_HI holds the clock high for a half period. On "fall" it returns to RD_LO, and on "last fall", after the sixteenth bit, it goes to FINISH. FINISH issues the valid pulse and goes back to IDLE ("done").

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset the strobe `cnv_o` is high, `sck_o` is low and `valid_o` is low.
- R2: When a start is accepted, `cnv_o` is low for exactly one clock cycle and then rises, which starts a conversion.
- R3: After that rise, `cnv_o` stays high for max(`conv_time_i`,1) cycles, and `sck_o` is never high while `cnv_o` is high.
- R4: With H = max(`half_div_i`,1), after the strobe falls `sck_o` stays low for H cycles. It then makes exactly 16 pulses, each high for H cycles, separated by low phases of H cycles.
- R5: `sdo_i` is sampled in the last system clock cycle before each falling edge of `sck_o`. The first sample is bit 15 (the most significant bit), so sixteen samples give bits 15 down to 0 in that order.
- R6: In the cycle after the sixteenth falling edge, `cnv_o` is high, `valid_o` is high and `data_o` holds the sampled word.
- R7: A start request is ignored while a frame is in progress (from acceptance until the return to IDLE). It produces no extra strobe edge and no extra valid pulse.
- R8: Two accepted starts are at least max(`cycle_time_i`,1) cycles apart. With start held high, successive valid pulses are max(`cycle_time_i`, C+32H+3) cycles apart, where C = max(`conv_time_i`,1).
- R9: `valid_o` is high for one cycle per frame only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to start a conversion |
| sdo_i | input | 1 | Serial data from the converter |
| half_div_i | input | TIME_W | Serial clock half period in system cycles (0 acts as 1) |
| conv_time_i | input | TIME_W | Worst-case conversion time in system cycles (0 acts as 1) |
| cycle_time_i | input | TIME_W | Minimum spacing between accepted starts in system cycles |
| cnv_o | output | 1 | Convert strobe and chip select |
| sck_o | output | 1 | Serial clock, idle low |
| data_o | output | DATA_W | Assembled result word |
| valid_o | output | 1 | One-cycle pulse marking `data_o` valid |

## Verification
The bench uses the default 16-bit word and 16-bit timing width, but drives the timing inputs with small values. The half period is swept over 0 to 3 and the conversion time over 0 to 4, so the clamp of zero to one and every strobe and clock phase length is covered. Each combination is run with several bit patterns, including alternating, single-bit and all-ones words. The cycle time is set below, equal to, one above and far above the frame length, which brings both sides of the spacing rule within reach in a few hundred cycles.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_CONV,
        ST_RD_LO,
        ST_RD_HI,
        ST_FINISH
    } rd_state_e;
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= val_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero_o = (cnt == '0);
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              din_i,
    output logic [DATA_W-1:0] data_o,
    output logic              last_o
);
    localparam int BIT_W = $clog2(DATA_W);

    logic [BIT_W-1:0] bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            bit_cnt <= '0;
        end else if (clr_i) begin
            bit_cnt <= '0;
        end else if (shift_i) begin
            data_o  <= {data_o[DATA_W-2:0], din_i};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign last_o = (bit_cnt == BIT_W'(DATA_W - 1));
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sdo_i,
    input  logic [TIME_W-1:0] half_div_i,
    input  logic [TIME_W-1:0] conv_time_i,
    input  logic [TIME_W-1:0] cycle_time_i,
    output logic              cnv_o,
    output logic              sck_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    rd_state_e state, nxt;

    logic              accept;
    logic              ph_zero, cyc_zero;
    logic              ph_load, shift_en, last_bit;
    logic [TIME_W-1:0] ph_val, conv_m1, half_m1, cyc_m1;

    assign conv_m1 = (conv_time_i  == '0) ? '0 : conv_time_i  - 1'b1;
    assign half_m1 = (half_div_i   == '0) ? '0 : half_div_i   - 1'b1;
    assign cyc_m1  = (cycle_time_i == '0) ? '0 : cycle_time_i - 1'b1;

    assign accept   = (state == ST_IDLE) && start_i && cyc_zero;
    assign ph_load  = (state == ST_PREP) ||
                      (((state == ST_CONV) || (state == ST_RD_LO) ||
                        (state == ST_RD_HI)) && ph_zero);
    assign ph_val   = (state == ST_PREP) ? conv_m1 : half_m1;
    assign shift_en = (state == ST_RD_HI) && ph_zero;

    adc_rd_timer #(.W(TIME_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ph_load),
        .val_i  (ph_val),
        .zero_o (ph_zero)
    );

    adc_rd_timer #(.W(TIME_W)) u_cycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .val_i  (cyc_m1),
        .zero_o (cyc_zero)
    );

    adc_rd_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .shift_i (shift_en),
        .din_i   (sdo_i),
        .data_o  (data_o),
        .last_o  (last_bit)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept)  nxt = ST_PREP;
            ST_PREP:                nxt = ST_CONV;
            ST_CONV:   if (ph_zero) nxt = ST_RD_LO;
            ST_RD_LO:  if (ph_zero) nxt = ST_RD_HI;
            ST_RD_HI:  if (ph_zero) nxt = last_bit ? ST_FINISH : ST_RD_LO;
            ST_FINISH:              nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // output decode
    always_comb begin
        cnv_o   = 1'b1;
        sck_o   = 1'b0;
        valid_o = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_PREP:   cnv_o = 1'b0;
            ST_CONV:   ;
            ST_RD_LO:  cnv_o = 1'b0;
            ST_RD_HI:  begin cnv_o = 1'b0; sck_o = 1'b1; end
            ST_FINISH: valid_o = 1'b1;
            default:   ;
        endcase
    end

    assert_sck_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_o |-> !sck_o);
    assert_sck_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> !cnv_o);
    assert_valid_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cnv_o && $past(sck_o)));
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_prep_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREP) |=> cnv_o);
    assert_cycle_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREP) |-> $past(cyc_zero));
endmodule

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
    localparam int PERIOD = 10;
    localparam int DW = 16;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sdo = 1'b0;
    logic [TW-1:0] half = 1, conv = 1, cyc = 1;
    logic          cnv_o, sck_o, valid_o;
    logic [DW-1:0] data_o;

    int checks = 0;
    int fails  = 0;
    int quiet_bad = 0;

    logic [DW-1:0] dev_word = '0;
    int            dev_idx = DW - 1;

    always #(PERIOD/2) clk = ~clk;

    adc_rd_ctrl #(.DATA_W(DW), .TIME_W(TW)) u_adc_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sdo_i(sdo),
        .half_div_i(half), .conv_time_i(conv), .cycle_time_i(cyc),
        .cnv_o(cnv_o), .sck_o(sck_o), .data_o(data_o), .valid_o(valid_o)
    );

    // converter model: MSB on strobe fall, next bit shortly after each sck fall
    always @(negedge cnv_o) begin
        dev_idx = DW - 1;
        sdo = dev_word[DW-1];
    end
    always @(negedge sck_o) begin
        #1;
        if (dev_idx > 0) dev_idx = dev_idx - 1;
        sdo = dev_word[dev_idx];
    end
    always @(posedge sck_o) if (cnv_o) quiet_bad++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input int h, input int c, input logic [DW-1:0] w, input bit poke);
        int he = (h == 0) ? 1 : h;
        int ce = (c == 0) ? 1 : c;
        int nconv = 0, first_lo = 0, hi = 0, rises = 0, rd = 0, guard = 0;
        bit prev = 0, seen_rise = 0;
        half = TW'(h); conv = TW'(c); cyc = 1; dev_word = w; quiet_bad = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(cnv_o == 1'b0, "R2 strobe low one cycle", int'(cnv_o), 0);
        @(negedge clk);
        while (cnv_o && guard < 5000) begin nconv++; guard++; @(negedge clk); end
        check(nconv == ce, "R3 conversion length", nconv, ce);
        while (!valid_o && guard < 5000) begin
            guard++; rd++;
            if (sck_o) begin hi++; if (!prev) rises++; seen_rise = 1; end
            else if (!seen_rise) first_lo++;
            if (poke) start = (hi == 5);
            prev = sck_o;
            @(negedge clk);
        end
        start = 1'b0;
        check(first_lo == he, "R4 low before first rise", first_lo, he);
        check(rises == DW, "R4 pulse count", rises, DW);
        check(hi == DW * he, "R4 high cycles", hi, DW * he);
        check(rd == 2 * DW * he, "R4 read length", rd, 2 * DW * he);
        check(quiet_bad == 0, "R3 sck quiet during conversion", quiet_bad, 0);
        check(data_o == w, "R5 R6 word", int'(data_o), int'(w));
        check(cnv_o == 1'b1, "R6 strobe high at valid", int'(cnv_o), 1);
        @(negedge clk);
        check(valid_o == 1'b0, "R9 single valid", int'(valid_o), 0);
    endtask

    task automatic run_spacing(input int h, input int c, input int ct);
        int ce = (c == 0) ? 1 : c;
        int he = (h == 0) ? 1 : h;
        int frame = ce + 32 * he + 3;
        int exp = (ct > frame) ? ct : frame;
        int gap = 0, guard = 0;
        half = TW'(h); conv = TW'(c); cyc = TW'(ct);
        @(negedge clk); start = 1'b1;
        while (!valid_o && guard < 5000) begin guard++; @(negedge clk); end
        @(negedge clk); gap = 1;
        while (!valid_o && guard < 5000) begin guard++; gap++; @(negedge clk); end
        check(gap == exp, "R8 start spacing", gap, exp);
        start = 1'b0;
        while (!(cnv_o && !valid_o) && guard < 5000) begin guard++; @(negedge clk); end
        repeat (ct + 2) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] pats [5];
        int stray;
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3;
        pats[3] = 16'h8001; pats[4] = 16'h5555;
        repeat (3) @(negedge clk);
        check(cnv_o == 1'b1 && sck_o == 1'b0 && valid_o == 1'b0, "R1 reset state",
              {cnv_o, sck_o, valid_o}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        for (int h = 0; h <= 3; h++)
            for (int c = 0; c <= 4; c++)
                for (int p = 0; p < 5; p++)
                    run_frame(h, c, pats[p] ^ DW'(h * 16'h1111 + c * 16'h0101), 1'b0);
        // R7: start pulse during readout must not launch another frame
        run_frame(2, 3, 16'h3C96, 1'b1);
        stray = 0;
        repeat (60) begin
            @(negedge clk);
            if (!cnv_o || valid_o) stray++;
        end
        check(stray == 0, "R7 start ignored mid-frame", stray, 0);
        // R8 boundaries around frame length 37 (h=1, c=2)
        run_spacing(1, 2, 10);
        run_spacing(1, 2, 37);
        run_spacing(1, 2, 38);
        run_spacing(1, 2, 150);
        run_spacing(0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule